// File: doc/BRIEF.md
# Truncated Egress Timestamp Capture and Expansion

This block holds, for each of a set of switch ports, the most recent egress timestamp in truncated form: only the low bits of the free-running tick counter are kept. Each stored value comes with an update flag. The flag rises when a new capture lands in the slot and falls when software reads the flag word. Software polls the flag word a bounded number of times until the flag is set, and then reads the timestamp.

Two register layouts are available, chosen by the width parameter. In the narrow layout (widths below 32, typically 24) one 32-bit word carries both items: the timestamp sits in the top bits and the flag in bit 0. In the wide layout (32 bits) there are two words. Word 0 carries the flag in bit 0, and word 1 carries the whole timestamp.

A separate expansion unit turns a truncated value back into a full 64-bit time. It uses a later sample of the running clock. The upper bits come from the current time, and the result is moved back by one wrap period whenever the current low bits do not exceed the truncated value. The result is only meaningful if the expansion happens within one wrap period of the capture. At 8 ns per tick, that window is about 0.13 s for 24 bits and about 34 s for 32 bits.

Top module: `egr_ts_top`

## Requirements
- R1: After reset, every update flag is clear, and rd_valid, rd_data, rc_valid and rc_full are all zero.
- R2: When cap_valid is high at a clock edge, the low PART_BITS of cap_time are stored in the slot selected by cap_port, and that slot's update flag is set.
- R3: Narrow layout (PART_BITS < 32). Word 0 reads as {timestamp, zeros, flag}: the timestamp occupies bits 31 down to 32-PART_BITS, the flag is bit 0, and the bits between them are zero. Word 1 reads as all zeros.
- R4: Wide layout (PART_BITS = 32). Word 0 reads as the flag in bit 0 with bits 31:1 zero. Word 1 reads as the 32-bit timestamp.
- R5: The read of (rd_port, rd_word) issued with rd_en returns its data on rd_data, with rd_valid high, exactly one cycle later. The data shows the slot contents as they were before that clock edge.
- R6: A read of word 0 (rd_word = 0) clears the selected slot's update flag. A read of word 1 leaves the flag unchanged.
- R7: A capture into a slot whose flag is already set overwrites the stored timestamp and leaves the flag set. A capture and a word-0 read of the same slot in the same cycle leave the flag set.
- R8: Expansion result. The upper 64-PART_BITS bits of rc_now are joined with rc_partial as the low bits. If rc_now's low PART_BITS are less than or equal to rc_partial, 2^PART_BITS is subtracted from the result, modulo 2^64. Equality counts as a wrap.
- R9: rc_valid is high exactly in the cycle after rc_req, and rc_full then carries that request's result. rc_full holds its value until the next request.
- R10: A capture or a read on one slot changes neither the flag nor the timestamp of any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Capture strobe |
| cap_port | input | PORT_W | Slot written by the capture |
| cap_time | input | 64 | Current tick count at capture |
| rd_en | input | 1 | Register read strobe |
| rd_port | input | PORT_W | Slot being read |
| rd_word | input | 1 | Word select: 0 is the flag word, 1 is the second word |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data word |
| rc_req | input | 1 | Expansion request |
| rc_partial | input | PART_BITS | Truncated timestamp to expand |
| rc_now | input | 64 | Current tick count sampled for the expansion |
| rc_valid | output | 1 | Expansion result valid |
| rc_full | output | 64 | Expanded 64-bit time |

## Verification
On every cycle, the assertions check the following:
- a flag can only fall after a word-0 read of its slot;
- a capture always leaves its slot's flag set, even when a read of that slot happens in the same cycle;
- both result strobes trail their requests by one cycle;
- in a read word, the bits outside the defined fields are zero;
- an expanded time keeps the partial value as its low bits, lies at or below the sampled clock, and lies within one wrap period of it.

Only the bench's scenarios can show the remaining behaviour, using its reference model for both layouts:
- that the exact stored timestamp is returned for the right port;
- the equality case of the wrap rule;
- the modulo-2^64 result when the clock's upper bits are still zero;
- that the other slots are left untouched.

// File: rtl/egr_ts_pkg.sv
package egr_ts_pkg;

  localparam int unsigned TIME_W = 64;
  localparam int unsigned WORD_W = 32;

  // Expand a truncated stamp against a later clock sample (R8).
  function automatic logic [TIME_W-1:0] expand_time(
    input logic [TIME_W-1:0] now,
    input logic [TIME_W-1:0] part,
    input int unsigned       nbits
  );
    logic [TIME_W-1:0] mask;
    logic [TIME_W-1:0] res;
    mask = (TIME_W'(1) << nbits) - TIME_W'(1);
    res  = (now & ~mask) | (part & mask);
    if ((now & mask) <= (part & mask))
      res = res - (mask + TIME_W'(1));
    return res;
  endfunction

  // Register word image for one slot (R3, R4).
  function automatic logic [WORD_W-1:0] slot_word(
    input logic              hi_word,
    input logic [WORD_W-1:0] stamp,
    input logic              flag,
    input int unsigned       nbits
  );
    logic [WORD_W-1:0] w;
    if (nbits < WORD_W)
      w = hi_word ? '0 : ((stamp << (WORD_W - nbits)) | {{(WORD_W-1){1'b0}}, flag});
    else
      w = hi_word ? stamp : {{(WORD_W-1){1'b0}}, flag};
    return w;
  endfunction

endpackage

// File: rtl/egr_ts_slot.sv
module egr_ts_slot #(
  parameter int unsigned PART_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_hit,
  input  logic [PART_BITS-1:0] cap_stamp,
  input  logic                 rd_clr,
  output logic [PART_BITS-1:0] stamp,
  output logic                 flag
);

  // Capture wins over a same-cycle clear (R7).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp <= '0;
      flag  <= 1'b0;
    end else begin
      if (cap_hit) begin
        stamp <= cap_stamp;
        flag  <= 1'b1;
      end else if (rd_clr) begin
        flag  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/egr_ts_expand.sv
module egr_ts_expand
  import egr_ts_pkg::*;
#(
  parameter int unsigned PART_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [PART_BITS-1:0] partial,
  input  logic [TIME_W-1:0]    now,
  output logic                 valid,
  output logic [TIME_W-1:0]    full
);

  logic [TIME_W-1:0] full_c;

  assign full_c = expand_time(now, TIME_W'(partial), PART_BITS);

  // Registered one cycle after the request, held otherwise (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      full  <= '0;
    end else begin
      valid <= req;
      if (req) full <= full_c;
    end
  end

endmodule

// File: rtl/egr_ts_top.sv
module egr_ts_top
  import egr_ts_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PART_BITS = 24,
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_valid,
  input  logic [PORT_W-1:0]    cap_port,
  input  logic [63:0]          cap_time,
  input  logic                 rd_en,
  input  logic [PORT_W-1:0]    rd_port,
  input  logic                 rd_word,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  input  logic                 rc_req,
  input  logic [PART_BITS-1:0] rc_partial,
  input  logic [63:0]          rc_now,
  output logic                 rc_valid,
  output logic [63:0]          rc_full
);

  // Per-slot events, brought out for the checker.
  logic [NUM_PORTS-1:0] cap_hit_vec;
  logic [NUM_PORTS-1:0] rd_clr_vec;
  logic [NUM_PORTS-1:0] slot_flag;
  logic [PART_BITS-1:0] slot_stamp [NUM_PORTS];
  logic [PART_BITS-1:0] sel_stamp;
  logic                 sel_flag;
  logic [63:0]          unused_cap_hi;

  assign unused_cap_hi = cap_time;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
    assign cap_hit_vec[p] = cap_valid && (cap_port == PORT_W'(p));
    assign rd_clr_vec[p]  = rd_en && !rd_word && (rd_port == PORT_W'(p));

    egr_ts_slot #(.PART_BITS(PART_BITS)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_hit   (cap_hit_vec[p]),
      .cap_stamp (cap_time[PART_BITS-1:0]),
      .rd_clr    (rd_clr_vec[p]),
      .stamp     (slot_stamp[p]),
      .flag      (slot_flag[p])
    );
  end

  always_comb begin
    sel_stamp = '0;
    sel_flag  = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rd_port == PORT_W'(p)) begin
        sel_stamp = slot_stamp[p];
        sel_flag  = slot_flag[p];
      end
    end
  end

  // Read path: pre-edge contents, one cycle latency (R5).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= slot_word(rd_word, WORD_W'(sel_stamp), sel_flag, PART_BITS);
    end
  end

  egr_ts_expand #(.PART_BITS(PART_BITS)) u_expand (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (rc_req),
    .partial (rc_partial),
    .now     (rc_now),
    .valid   (rc_valid),
    .full    (rc_full)
  );

endmodule

// File: rtl/egr_ts_chk.sv
module egr_ts_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PART_BITS = 24,
  parameter int unsigned PORT_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cap_valid,
  input logic [PORT_W-1:0]    cap_port,
  input logic                 rd_en,
  input logic [PORT_W-1:0]    rd_port,
  input logic                 rd_word,
  input logic                 rd_valid,
  input logic [31:0]          rd_data,
  input logic                 rc_req,
  input logic [PART_BITS-1:0] rc_partial,
  input logic [63:0]          rc_now,
  input logic                 rc_valid,
  input logic [63:0]          rc_full,
  input logic [NUM_PORTS-1:0] slot_flag,
  input logic [NUM_PORTS-1:0] rd_clr_vec
);

  localparam logic [63:0] SPAN = 64'd1 << PART_BITS;

  a_r2_capture_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && (32'(cap_port) < NUM_PORTS)) |=> slot_flag[$past(cap_port)]);

  a_r6_flag_falls_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(slot_flag) & ~slot_flag & ~$past(rd_clr_vec))) == 1'b0);

  a_r7_capture_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && rd_en && !rd_word && cap_port == rd_port && (32'(cap_port) < NUM_PORTS))
      |=> slot_flag[$past(cap_port)]);

  a_r5_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r5_no_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  if (PART_BITS < 32) begin : g_narrow
    a_r3_hi_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_word)) |-> rd_data == 32'd0);
    a_r3_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !$past(rd_word)) |-> rd_data[31-PART_BITS:1] == '0);
  end else begin : g_wide
    a_r4_flag_word_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !$past(rd_word)) |-> rd_data[31:1] == 31'd0);
  end

  a_r8_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rc_valid |-> rc_full[PART_BITS-1:0] == $past(rc_partial));

  a_r8_within_one_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_valid && $past(rc_now) >= SPAN)
      |-> (rc_full <= $past(rc_now)) && (($past(rc_now) - rc_full) <= SPAN));

  a_r9_result_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rc_req |=> rc_valid);

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_req |=> (!rc_valid && $stable(rc_full)));

endmodule

bind egr_ts_top egr_ts_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PART_BITS (PART_BITS),
  .PORT_W    (PORT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_valid  (cap_valid),
  .cap_port   (cap_port),
  .rd_en      (rd_en),
  .rd_port    (rd_port),
  .rd_word    (rd_word),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .rc_req     (rc_req),
  .rc_partial (rc_partial),
  .rc_now     (rc_now),
  .rc_valid   (rc_valid),
  .rc_full    (rc_full),
  .slot_flag  (slot_flag),
  .rd_clr_vec (rd_clr_vec)
);

// File: tb/test_egr_ts_top.sv
module test_egr_ts_top;

  localparam int NP = 4;
  localparam int NB = 24;
  localparam int WB = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0;
  logic [1:0]  cap_port = '0;
  logic [63:0] cap_time = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_port = '0;
  logic        rd_word = 1'b0;
  logic        rc_req = 1'b0;
  logic [31:0] rc_part = '0;
  logic [63:0] rc_now = '0;

  logic        rd_valid_n, rd_valid_w, rc_valid_n, rc_valid_w;
  logic [31:0] rd_data_n, rd_data_w;
  logic [63:0] rc_full_n, rc_full_w;

  always #10 clk = ~clk;

  egr_ts_top #(.NUM_PORTS(NP), .PART_BITS(NB)) i_egr_ts_top (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_port(cap_port), .cap_time(cap_time),
    .rd_en(rd_en), .rd_port(rd_port), .rd_word(rd_word), .rd_valid(rd_valid_n), .rd_data(rd_data_n),
    .rc_req(rc_req), .rc_partial(rc_part[NB-1:0]), .rc_now(rc_now),
    .rc_valid(rc_valid_n), .rc_full(rc_full_n));

  egr_ts_top #(.NUM_PORTS(NP), .PART_BITS(WB)) i_egr_ts_top_w (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_port(cap_port), .cap_time(cap_time),
    .rd_en(rd_en), .rd_port(rd_port), .rd_word(rd_word), .rd_valid(rd_valid_w), .rd_data(rd_data_w),
    .rc_req(rc_req), .rc_partial(rc_part), .rc_now(rc_now),
    .rc_valid(rc_valid_w), .rc_full(rc_full_w));

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  bit    started = 0;
  string cur_tag = "R1";

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference, written from the requirements.
  function automatic logic [31:0] ref_word(int n, logic hi, logic [63:0] st, logic fl);
    logic [63:0] v;
    if (n < 32) begin
      v = (st % (64'd1 << n)) << (32 - n);
      return hi ? 32'd0 : (v[31:0] | {31'd0, fl});
    end
    return hi ? st[31:0] : {31'd0, fl};
  endfunction

  function automatic logic [63:0] ref_expand(int n, logic [63:0] now, logic [63:0] part);
    logic [63:0] span, base, cand;
    span = 64'd1 << n;
    base = now - (now % span);
    cand = base + (part % span);
    if (cand >= now) cand = cand - span;
    return cand;
  endfunction

  logic [63:0] m_st [NP];
  logic        m_fl [NP];
  logic        e_rd_valid = 0, e_rc_valid = 0;
  logic [31:0] e_rd_n = 0, e_rd_w = 0;
  logic [63:0] e_rc_n = 0, e_rc_w = 0;
  string       e_tag = "R1";

  always @(posedge clk) begin
    started = 1;
    e_tag = cur_tag;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_st[p] = '0; m_fl[p] = 0; end
      e_rd_valid = 0; e_rc_valid = 0; e_rd_n = 0; e_rd_w = 0; e_rc_n = 0; e_rc_w = 0;
    end else begin
      e_rd_valid = rd_en;
      if (rd_en) begin
        e_rd_n = ref_word(NB, rd_word, m_st[rd_port], m_fl[rd_port]);
        e_rd_w = ref_word(WB, rd_word, m_st[rd_port], m_fl[rd_port]);
        if (!rd_word) m_fl[rd_port] = 0;
      end
      if (cap_valid) begin m_st[cap_port] = cap_time; m_fl[cap_port] = 1; end
      e_rc_valid = rc_req;
      if (rc_req) begin
        e_rc_n = ref_expand(NB, rc_now, {32'd0, rc_part});
        e_rc_w = ref_expand(WB, rc_now, {32'd0, rc_part});
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(e_tag, "rd_valid narrow", {63'd0, rd_valid_n}, {63'd0, e_rd_valid});
      chk(e_tag, "rd_valid wide", {63'd0, rd_valid_w}, {63'd0, e_rd_valid});
      if (e_rd_valid || !rst_n) begin
        chk(e_tag, "rd_data narrow", {32'd0, rd_data_n}, {32'd0, e_rd_n});
        chk(e_tag, "rd_data wide", {32'd0, rd_data_w}, {32'd0, e_rd_w});
      end
      chk(e_tag, "rc_valid", {62'd0, rc_valid_n, rc_valid_w}, {62'd0, e_rc_valid, e_rc_valid});
      chk(e_tag, "rc_full narrow", rc_full_n, e_rc_n);
      chk(e_tag, "rc_full wide", rc_full_w, e_rc_w);
    end
  end

  task automatic tick();
    @(negedge clk);
    cap_valid = 0; rd_en = 0; rc_req = 0;
  endtask

  task automatic cap(int p, logic [63:0] t);
    cap_valid = 1; cap_port = 2'(p); cap_time = t;
  endtask

  task automatic rd(int p, logic w);
    rd_en = 1; rd_port = 2'(p); rd_word = w;
  endtask

  task automatic rq(logic [31:0] part, logic [63:0] now);
    rc_req = 1; rc_part = part; rc_now = now;
  endtask

  initial begin
    // R1: reset state, then flag word of an idle slot reads zero
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_tag = "R1"; rd(0, 0); tick(); tick();
    // R2 R3 R4: capture then read both words
    cur_tag = "R2"; cap(1, 64'h0000_0012_3456_789A); tick();
    cur_tag = "R4"; rd(1, 1); tick();
    cur_tag = "R3"; rd(1, 0); tick();
    // R6: flag word read cleared the flag, word 1 read had not
    cur_tag = "R6"; rd(1, 0); tick(); rd(1, 1); tick(); rd(1, 0); tick();
    // R7: overwrite with flag set; capture and clear together
    cur_tag = "R7"; cap(2, 64'h11); tick(); cap(2, 64'hABCD_EF01_2345); tick();
    rd(2, 0); tick(); rd(2, 1); tick();
    cap(3, 64'h77_0000_0042); rd(3, 0); tick(); rd(3, 0); tick(); rd(3, 0); tick();
    // R5: back-to-back reads of different slots
    cur_tag = "R5"; rd(2, 1); tick(); rd(3, 1); tick(); rd(1, 1); tick();
    // R10: other slots untouched by traffic on slot 2
    cur_tag = "R10"; cap(0, 64'h5555_AAAA); tick(); cap(2, 64'h9); rd(2, 0); tick();
    rd(0, 0); tick(); rd(0, 1); tick(); rd(1, 1); tick();
    // R8: no wrap, equality, wrap, zero upper bits
    cur_tag = "R8"; rq(32'h0000_0005, 64'h0000_0005_0100_0010); tick();
    rq(32'h0100_0010, 64'h0000_0005_0100_0010); tick();
    rq(32'hFFFF_FFF0, 64'h0000_0005_0100_0010); tick();
    rq(32'h0000_0020, 64'h0000_0000_0000_0010); tick();
    rq(32'h00FF_FFFF, 64'h0000_0001_0000_0000); tick();
    // R9: result held while idle
    cur_tag = "R9"; tick(); tick(); rq(32'h3, 64'h100_0004); tick(); tick();
    // Mixed traffic
    cur_tag = "R5";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) cap($urandom_range(0, 3), {$urandom, $urandom});
      if ($urandom_range(0, 1) == 0) rd($urandom_range(0, 3), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 2) == 0) rq($urandom, {32'($urandom_range(0, 3)), $urandom});
      tick();
    end
    tick(); tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R5: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule